// File: doc/BRIEF.md
# Branch and Skip Program-Counter Update Unit

This unit works out the next program-counter value for the control-transfer instructions of an 8-bit processor with a 16-bit program counter. It handles three instruction groups: two-byte short branches, three-byte long branches and long skips. The sequencer raises `start` in the first execute cycle. In that cycle it presents the opcode, the program counter (already pointing at the first operand byte) and the first byte read from memory. In the same cycle the unit samples the condition inputs: D zero, DF, Q, the external flags and interrupt enable.

A short branch finishes after one execute cycle. A taken short branch writes the operand only into the low byte of the program counter, so control stays within the current 256-byte page. An untaken short branch steps over the operand. A long instruction spends a second execute cycle, in which the second operand byte is presented. A taken long branch loads a full 16-bit address, with the high byte first. An untaken long branch, and a long skip whose condition holds, both step the counter by two. All increments wrap around at 65536.

Top module: `pc_branch_unit`

## Requirements
- R1: After reset, `done`, `busy`, `taken`, `exec_cycles` and `pc_out` are all zero.
- R2: A short branch (opcode 0x30 to 0x3F) accepted with `start` raises `done` at the next clock edge with `exec_cycles` = 1. When the branch is taken, `pc_out` = {`pc_in`[15:8], `op_byte`} and `taken` = 1.
- R3: An untaken short branch gives `pc_out` = `pc_in` + 1 and `taken` = 0. Opcode 0x38 is never taken, so it acts as a one-cycle skip over a single byte.
- R4: Short-branch condition: opcode bits [2:0] select 0 = always, 1 = Q, 2 = D zero, 3 = DF, 4 to 7 = external flag `ef`[0] to `ef`[3]. Opcode bit 3 set inverts the test.
- R5: A long branch (0xC0 to 0xC3, 0xC8 to 0xCB) uses bits [1:0] as the selector (0 = always, 1 = Q, 2 = D zero, 3 = DF), and bit 3 inverts the test. The result appears two edges after `start` with `exec_cycles` = 2. When taken, `pc_out` = {first byte, second byte}; otherwise `pc_out` = `pc_in` + 2.
- R6: A long skip (0xC4 to 0xC7, 0xCC to 0xCF) skips when its selected Q, D zero or DF condition equals opcode bit 3. 0xCC skips when `ie` = 1, and 0xC4 never skips. A skip gives `pc_in` + 2; otherwise `pc_out` = `pc_in`. `exec_cycles` = 2.
- R7: The condition inputs are sampled only in the `start` cycle. Changing them during the second execute cycle does not alter the result.
- R8: A `start` that arrives while `busy` is high is ignored, and it produces no extra `done`.
- R9: A `start` with an opcode outside the 0x3_ and 0xC_ groups produces neither `done` nor `busy`.
- R10: Every program-counter increment wraps modulo 65536.
- R11: `busy` is high exactly during the second execute cycle of a long instruction, and it is followed by `done` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per machine cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | First execute cycle of a branch or skip |
| opcode | input | 8 | Instruction byte |
| pc_in | input | 16 | Program counter pointing at the first operand byte |
| op_byte | input | 8 | Operand byte read in the current execute cycle |
| d_zero | input | 1 | Accumulator equals zero |
| df | input | 1 | Carry/borrow flag |
| q | input | 1 | Single-bit output latch state |
| ef | input | 4 | External flag inputs |
| ie | input | 1 | Interrupt enable |
| done | output | 1 | New program counter valid this cycle |
| pc_out | output | 16 | Updated program counter |
| exec_cycles | output | 2 | Execute cycles the instruction used |
| taken | output | 1 | Branch taken or skip performed |
| busy | output | 1 | Second execute cycle in progress |

## Verification
The hardest case to reach from the ports is a change on the condition inputs, or a second `start`, landing in exactly the second execute cycle of a long instruction. That is the only window in which stale sampling or a lost busy guard would show. The bench's long-instruction task takes separate condition vectors for each execute cycle and can inject a competing short-branch `start` in the second cycle. Results are then compared against the first-cycle conditions, and the following cycle is checked for the absence of a stray `done`. Wrap-around is reached by putting the operand pointer at 0xFFFE and 0xFFFF.

// File: rtl/pbu_pkg.sv
package pbu_pkg;
  typedef enum logic [1:0] {
    CL_NONE  = 2'd0,
    CL_SHORT = 2'd1,
    CL_LBR   = 2'd2,
    CL_LSKP  = 2'd3
  } op_class_t;

  localparam logic [3:0] GRP_SHORT = 4'h3;
  localparam logic [3:0] GRP_LONG  = 4'hC;
endpackage

// File: rtl/pbu_decode.sv
module pbu_decode
  import pbu_pkg::*;
(
  input  logic [7:0] opcode,
  output op_class_t  cls,
  output logic [2:0] sel,
  output logic       inv
);
  always_comb begin
    if (opcode[7:4] == GRP_SHORT)
      cls = CL_SHORT;
    else if (opcode[7:4] == GRP_LONG)
      cls = opcode[2] ? CL_LSKP : CL_LBR;
    else
      cls = CL_NONE;
  end

  assign sel = opcode[2:0];
  assign inv = opcode[3];
endmodule

// File: rtl/pbu_cond.sv
module pbu_cond
  import pbu_pkg::*;
#(
  parameter int NUM_EF = 4
) (
  input  op_class_t         cls,
  input  logic [2:0]        sel,
  input  logic              inv,
  input  logic              d_zero,
  input  logic              df,
  input  logic              q,
  input  logic [NUM_EF-1:0] ef,
  input  logic              ie,
  output logic              hit
);
  localparam int N_CAND = 8;

  logic [N_CAND-1:0] cand;
  logic              base;

  assign cand[0] = 1'b1;
  assign cand[1] = q;
  assign cand[2] = d_zero;
  assign cand[3] = df;

  genvar gi;
  generate
    for (gi = 0; gi < 4; gi++) begin : g_flag
      if (gi < NUM_EF) begin : g_have
        assign cand[4+gi] = ef[gi];
      end else begin : g_tie
        assign cand[4+gi] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    if (cls == CL_SHORT)
      base = cand[sel];
    else
      base = cand[{1'b0, sel[1:0]}];
  end

  always_comb begin
    unique case (cls)
      CL_SHORT, CL_LBR: hit = base ^ inv;
      CL_LSKP:          hit = (sel[1:0] == 2'd0) ? (inv & ie) : (base == inv);
      default:          hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pbu_seq.sv
module pbu_seq
  import pbu_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  op_class_t       cls,
  input  logic            hit,
  input  logic [PC_W-1:0] pc_in,
  input  logic [PC_W/2-1:0] op_byte,
  output logic            accept_evt,
  output logic            done,
  output logic [PC_W-1:0] pc_out,
  output logic [1:0]      exec_cycles,
  output logic            taken,
  output logic            busy
);
  localparam int BYTE_W = PC_W / 2;

  function automatic logic [PC_W-1:0] pc_step(input logic [PC_W-1:0] p, input int unsigned n);
    pc_step = p + PC_W'(n);
  endfunction

  function automatic logic [PC_W-1:0] page_jump(input logic [PC_W-1:0] p, input logic [BYTE_W-1:0] lo);
    page_jump = {p[PC_W-1:BYTE_W], lo};
  endfunction

  typedef enum logic {ST_IDLE = 1'b0, ST_SECOND = 1'b1} st_t;

  st_t              state;
  op_class_t        cls_q;
  logic             hit_q;
  logic [PC_W-1:0]  pc_q;
  logic [BYTE_W-1:0] hi_q;
  logic [PC_W-1:0]  short_nxt;
  logic [PC_W-1:0]  long_nxt;

  assign accept_evt = start && (state == ST_IDLE) && (cls != CL_NONE);
  assign busy       = (state == ST_SECOND);

  always_comb begin
    short_nxt = hit ? page_jump(pc_in, op_byte) : pc_step(pc_in, 1);
  end

  always_comb begin
    if (cls_q == CL_LBR)
      long_nxt = hit_q ? {hi_q, op_byte} : pc_step(pc_q, 2);
    else
      long_nxt = hit_q ? pc_step(pc_q, 2) : pc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cls_q       <= CL_NONE;
      hit_q       <= 1'b0;
      pc_q        <= '0;
      hi_q        <= '0;
      done        <= 1'b0;
      pc_out      <= '0;
      exec_cycles <= 2'd0;
      taken       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_SECOND) begin
        state       <= ST_IDLE;
        done        <= 1'b1;
        pc_out      <= long_nxt;
        exec_cycles <= 2'd2;
        taken       <= hit_q;
      end else if (accept_evt) begin
        if (cls == CL_SHORT) begin
          done        <= 1'b1;
          pc_out      <= short_nxt;
          exec_cycles <= 2'd1;
          taken       <= hit;
        end else begin
          state <= ST_SECOND;
          cls_q <= cls;
          hit_q <= hit;
          pc_q  <= pc_in;
          hi_q  <= op_byte;
        end
      end
    end
  end
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pbu_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int NUM_EF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [PC_W/2-1:0] op_byte,
  input  logic              d_zero,
  input  logic              df,
  input  logic              q,
  input  logic [NUM_EF-1:0] ef,
  input  logic              ie,
  output logic              done,
  output logic [PC_W-1:0]   pc_out,
  output logic [1:0]        exec_cycles,
  output logic              taken,
  output logic              busy
);
  op_class_t  cls_w;
  logic [2:0] sel_w;
  logic       inv_w;
  logic       hit_w;
  logic       accept_evt;

  pbu_decode u_dec (
    .opcode (opcode),
    .cls    (cls_w),
    .sel    (sel_w),
    .inv    (inv_w)
  );

  pbu_cond #(.NUM_EF(NUM_EF)) u_cond (
    .cls    (cls_w),
    .sel    (sel_w),
    .inv    (inv_w),
    .d_zero (d_zero),
    .df     (df),
    .q      (q),
    .ef     (ef),
    .ie     (ie),
    .hit    (hit_w)
  );

  pbu_seq #(.PC_W(PC_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cls         (cls_w),
    .hit         (hit_w),
    .pc_in       (pc_in),
    .op_byte     (op_byte),
    .accept_evt  (accept_evt),
    .done        (done),
    .pc_out      (pc_out),
    .exec_cycles (exec_cycles),
    .taken       (taken),
    .busy        (busy)
  );
endmodule

// File: rtl/pbu_checker.sv
module pbu_checker #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [7:0]      opcode,
  input logic [PC_W-1:0] pc_in,
  input logic            accept_evt,
  input logic            done,
  input logic [PC_W-1:0] pc_out,
  input logic [1:0]      exec_cycles,
  input logic            taken,
  input logic            busy
);
  p_short_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && opcode[7:4] == 4'h3 |=> done && exec_cycles == 2'd1 && !busy);

  p_page_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && opcode[7:4] == 4'h3 |=>
      (!taken || pc_out[PC_W-1:PC_W/2] == $past(pc_in[PC_W-1:PC_W/2])));

  p_untaken_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && opcode[7:4] == 4'h3 |=>
      (taken || pc_out == PC_W'($past(pc_in) + 1'b1)));

  p_long_second_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && opcode[7:4] == 4'hC |=> busy && !done);

  p_accept_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> !busy);

  p_bad_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && opcode[7:4] != 4'h3 && opcode[7:4] != 4'hC |=> !done && !busy);

  p_busy_completes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> done && !busy && exec_cycles == 2'd2);
endmodule

bind pc_branch_unit pbu_checker #(.PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .opcode      (opcode),
  .pc_in       (pc_in),
  .accept_evt  (accept_evt),
  .done        (done),
  .pc_out      (pc_out),
  .exec_cycles (exec_cycles),
  .taken       (taken),
  .busy        (busy)
);

// File: tb/sim_pc_branch_unit.sv
`timescale 1ns/1ps
module sim_pc_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] pc_in = '0;
  logic [7:0]  op_byte = '0;
  logic        d_zero = 1'b0, df = 1'b0, q = 1'b0, ie = 1'b0;
  logic [3:0]  ef = '0;
  logic        done, taken, busy;
  logic [15:0] pc_out;
  logic [1:0]  exec_cycles;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pc_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .pc_in(pc_in),
    .op_byte(op_byte), .d_zero(d_zero), .df(df), .q(q), .ef(ef), .ie(ie),
    .done(done), .pc_out(pc_out), .exec_cycles(exec_cycles), .taken(taken), .busy(busy)
  );

  // condition vector: {ie, ef[3:0], q, df, d_zero}
  task automatic put_cond(input logic [7:0] c);
    d_zero = c[0]; df = c[1]; q = c[2]; ef = c[6:3]; ie = c[7];
  endtask

  function automatic bit exp_hit(input logic [7:0] op, input logic [7:0] c);
    bit dz = c[0], f = c[1], qq = c[2], ien = c[7];
    bit r;
    if (op[7:4] == 4'h3) begin
      case (op[2:0])
        3'd0: r = 1;
        3'd1: r = qq;
        3'd2: r = dz;
        3'd3: r = f;
        default: r = c[3 + (op[2:0] - 4)];
      endcase
      if (op[3]) r = !r;
    end else begin
      case (op)
        8'hC0: r = 1;   8'hC1: r = qq;  8'hC2: r = dz;  8'hC3: r = f;
        8'hC8: r = 0;   8'hC9: r = !qq; 8'hCA: r = !dz; 8'hCB: r = !f;
        8'hC4: r = 0;   8'hC5: r = !qq; 8'hC6: r = !dz; 8'hC7: r = !f;
        8'hCC: r = ien; 8'hCD: r = qq;  8'hCE: r = dz;  8'hCF: r = f;
        default: r = 0;
      endcase
    end
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "done", 16'(done), 0);
    chk("R1", "busy", 16'(busy), 0);
    chk("R1", "taken", 16'(taken), 0);
    chk("R1", "exec", 16'(exec_cycles), 0);
    chk("R1", "pc_out", pc_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_short(input logic [7:0] op, input logic [15:0] pc, input logic [7:0] b,
                           input logic [7:0] c, input string req);
    bit h = exp_hit(op, c);
    logic [15:0] e = h ? {pc[15:8], b} : pc + 16'd1;
    start = 1; opcode = op; pc_in = pc; op_byte = b; put_cond(c);
    @(negedge clk);
    start = 0;
    chk(req, "short done", 16'(done), 1);
    chk(req, "short exec", 16'(exec_cycles), 1);
    chk(req, "short taken", 16'(taken), 16'(h));
    chk(req, "short pc", pc_out, e);
    @(negedge clk);
  endtask

  task automatic run_long(input logic [7:0] op, input logic [15:0] pc, input logic [7:0] b1,
                          input logic [7:0] b2, input logic [7:0] c1, input logic [7:0] c2,
                          input bit inject, input string req);
    bit h = exp_hit(op, c1);
    logic [15:0] e;
    if (op[2] == 1'b0) e = h ? {b1, b2} : pc + 16'd2;
    else               e = h ? pc + 16'd2 : pc;
    start = 1; opcode = op; pc_in = pc; op_byte = b1; put_cond(c1);
    @(negedge clk);
    chk("R11", "busy in second cycle", 16'(busy), 1);
    chk("R11", "no done in second cycle", 16'(done), 0);
    op_byte = b2; put_cond(c2);
    if (inject) begin start = 1; opcode = 8'h30; pc_in = 16'h1234; end
    else start = 0;
    @(negedge clk);
    start = 0;
    chk(req, "long done", 16'(done), 1);
    chk(req, "long exec", 16'(exec_cycles), 2);
    chk(req, "long taken", 16'(taken), 16'(h));
    chk(req, "long pc", pc_out, e);
    chk("R11", "busy cleared", 16'(busy), 0);
    @(negedge clk);
    if (inject) begin
      chk("R8", "no extra done", 16'(done), 0);
      chk("R8", "pc kept", pc_out, e);
    end
  endtask

  task automatic test_short_sweep();
    logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'h55, 8'hAA};
    for (int o = 0; o < 16; o++)
      for (int p = 0; p < 4; p++)
        run_short(8'h30 + 8'(o), 16'h4A10 + 16'(o), 8'h77 ^ 8'(p), pats[p], "R4");
  endtask

  task automatic test_short_cases();
    run_short(8'h30, 16'h2280, 8'h0C, 8'h00, "R2");
    run_short(8'h38, 16'h2280, 8'h0C, 8'hFF, "R3");
    run_short(8'h37, 16'h0100, 8'hEE, 8'h40, "R4");
    run_short(8'h3F, 16'h0100, 8'hEE, 8'h40, "R4");
    run_short(8'h38, 16'hFFFF, 8'h12, 8'h00, "R10");
  endtask

  task automatic test_long_branch();
    logic [7:0] ops [8] = '{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC8, 8'hC9, 8'hCA, 8'hCB};
    foreach (ops[i]) begin
      run_long(ops[i], 16'h3000, 8'h9A, 8'hBC, 8'h07, 8'h07, 0, "R5");
      run_long(ops[i], 16'h3000, 8'h9A, 8'hBC, 8'h00, 8'h00, 0, "R5");
    end
    run_long(8'hC8, 16'hFFFE, 8'h11, 8'h22, 8'h00, 8'h00, 0, "R10");
  endtask

  task automatic test_long_skip();
    logic [7:0] ops [8] = '{8'hC4, 8'hC5, 8'hC6, 8'hC7, 8'hCC, 8'hCD, 8'hCE, 8'hCF};
    foreach (ops[i]) begin
      run_long(ops[i], 16'h5000, 8'h01, 8'h02, 8'h87, 8'h87, 0, "R6");
      run_long(ops[i], 16'h5000, 8'h01, 8'h02, 8'h00, 8'h00, 0, "R6");
    end
    run_long(8'hCC, 16'hFFFF, 8'h00, 8'h00, 8'h80, 8'h80, 0, "R10");
  endtask

  task automatic test_sampling();
    run_long(8'hC1, 16'h6000, 8'hAB, 8'hCD, 8'h04, 8'h00, 0, "R7");
    run_long(8'hCE, 16'h6000, 8'hAB, 8'hCD, 8'h00, 8'h01, 0, "R7");
  endtask

  task automatic test_busy_start();
    run_long(8'hC0, 16'h7000, 8'h44, 8'h55, 8'h00, 8'h00, 1, "R8");
  endtask

  task automatic test_bad_op();
    logic [7:0] bad [3] = '{8'h00, 8'h7A, 8'hF3};
    foreach (bad[i]) begin
      start = 1; opcode = bad[i]; pc_in = 16'h0800;
      @(negedge clk);
      start = 0;
      chk("R9", "no done", 16'(done), 0);
      chk("R9", "no busy", 16'(busy), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    test_reset();
    test_short_cases();
    test_short_sweep();
    test_long_branch();
    test_long_skip();
    test_sampling();
    test_busy_start();
    test_bad_op();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule